// File: doc/BRIEF.md
# Interlaced Field Packetizer with Early Packet Termination

This block sits at the entry of a video pipeline. It receives active-video pixels of an interlaced source, one per clock when `pix_valid` is high, a pulse `field_start` that marks the first pixel of each field, and a `locked` level from the upstream sync logic. Each field is turned into two packets on a valid/ready stream. A short control packet gives the field's dimensions. An image packet then carries every pixel of the field.

A FIFO between the capture side and the stream side absorbs downstream backpressure. The capture side cannot stall the source. When the FIFO is about to run out of space, the block closes the image packet at once, with end-of-packet on the last pixel it stored. It does the same when lock is lost, using an extra terminating beat. It then throws away input until the next field start. A sticky overflow flag and a saturating count of truncated fields are available as plain outputs.

The dimensions (`LINE_PIX` by `LINES`, 720 by 288 by default) and the FIFO depth are parameters. `DEPTH` must be a power of two, at least 4.

Top module: `vidcap_packetizer`

## Requirements
- R1: After reset, `out_valid` is 0, `ovf_flag` is 0 and `trunc_count` is 0.
- R2: Each accepted field first produces a control packet of three beats. Beat one is 0x0F with `out_sop`=1. Beat two is `LINE_PIX`. Beat three is `LINES`, with `out_eop`=1.
- R3: The control packet is followed by an image packet. Its first beat is 0x00 with `out_sop`=1. Then come the field's pixels in arrival order. When the field is complete, `out_eop` is set on pixel number `LINE_PIX*LINES`.
- R4: A pixel that arrives during capture while the FIFO holds `DEPTH-1` entries is stored with `out_eop` set, and the image packet ends there. Every pixel accepted before it is delivered, so the payload is an unbroken prefix of the field. The FIFO never overflows.
- R5: If `locked` is low during capture, one terminating beat of data 0 with `out_eop`=1 is appended after the pixels already stored.
- R6: After any end of image packet, input pixels are ignored until a pixel arrives with `field_start`=1. That field then gets a fresh control packet and image packet.
- R7: `ovf_flag` goes high on the first FIFO-space shortfall and stays high until reset.
- R8: `trunc_count` increases by one for each image packet that is ended early, whether by FIFO space or by loss of lock. It saturates at its maximum value.
- R9: With `out_ready` held high, a field followed by a gap is never truncated, and `trunc_count` does not change.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_eop` hold their values on the next cycle.
- R11: A field whose first pixel finds fewer than two free FIFO entries is skipped entirely: it produces no packets and does not change `trunc_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Active pixel present this cycle |
| pix_data | input | DW | Pixel value |
| field_start | input | 1 | Marks the first pixel of a field |
| locked | input | 1 | Upstream sync lock indication |
| out_data | output | DW | Stream beat data |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| ovf_flag | output | 1 | Sticky FIFO-space shortfall flag |
| trunc_count | output | TW | Saturating count of truncated fields |

## Verification
The FIFO count, the capture state, the flag and the counter all update on the rising edge at which the triggering pixel or the low `locked` level is sampled. The first control beat is offered on the output two rising edges after the first pixel of a field is presented. An accepted stream beat moves the output on at the next edge. The bench drives every input one time unit after a rising edge and samples every output at the falling edge, so each value is read a half cycle after the edge that produced it. The exact position of an overflow depends on the ready pattern, so packet contents are checked after a drain window of at least a hundred cycles. Beat stability under backpressure is checked on every cycle.

// File: rtl/vidcap_pkg.sv
package vidcap_pkg;
    typedef enum logic {
        CAP_WAIT,
        CAP_RUN
    } cap_state_e;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_CTL_KIND,
        FR_CTL_WIDTH,
        FR_CTL_HEIGHT,
        FR_IMG_KIND,
        FR_PIXELS
    } frm_state_e;

    localparam logic [3:0] KIND_CONTROL = 4'hF;
    localparam logic [3:0] KIND_IMAGE   = 4'h0;
endpackage

// File: rtl/vidcap_fifo.sv
module vidcap_fifo #(
    parameter int EW    = 25,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_word,
    input  logic          rd_en,
    output logic [EW-1:0] head_word,
    output logic [CW-1:0] count,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [EW-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        ptr_d = ptr_q;
        do_wr = wr_en && (int'(ptr_q.cnt) < DEPTH);
        do_rd = rd_en && (ptr_q.cnt != '0);
        if (do_wr) ptr_d.wp = ptr_q.wp + 1'b1;
        if (do_rd) ptr_d.rp = ptr_q.rp + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[ptr_q.wp] <= wr_word;
    end

    assign head_word = mem_q[ptr_q.rp];
    assign count     = ptr_q.cnt;
    assign empty     = (ptr_q.cnt == '0);

    // R4: the writer never pushes into a full store
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(count) < DEPTH));
endmodule

// File: rtl/vidcap_writer.sv
module vidcap_writer
    import vidcap_pkg::*;
#(
    parameter int DW       = 24,
    parameter int LINE_PIX = 720,
    parameter int LINES    = 288,
    parameter int DEPTH    = 64,
    parameter int TW       = 16,
    localparam int CW      = $clog2(DEPTH) + 1,
    localparam int NPIX    = LINE_PIX * LINES,
    localparam int PCW     = $clog2(NPIX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic [DW-1:0] pix_data,
    input  logic          field_start,
    input  logic          locked,
    input  logic [CW-1:0] fifo_count,
    output logic          wr_en,
    output logic [DW:0]   wr_word,
    output logic          ovf_flag,
    output logic [TW-1:0] trunc_count
);
    typedef struct packed {
        cap_state_e     st;
        logic [PCW-1:0] npix;
        logic           ovf;
        logic [TW-1:0]  trunc;
    } wr_t;

    wr_t w_d, w_q;
    logic early;

    always_comb begin
        w_d     = w_q;
        wr_en   = 1'b0;
        wr_word = '0;
        early   = 1'b0;
        case (w_q.st)
            CAP_WAIT: begin
                if (pix_valid && field_start && locked) begin
                    if (int'(fifo_count) <= DEPTH - 2) begin
                        wr_en   = 1'b1;
                        wr_word = {(NPIX == 1), pix_data};
                        w_d.npix = PCW'(1);
                        w_d.st   = (NPIX == 1) ? CAP_WAIT : CAP_RUN;
                    end else begin
                        w_d.ovf = 1'b1;
                    end
                end
            end
            CAP_RUN: begin
                if (!locked) begin
                    wr_en   = 1'b1;
                    wr_word = {1'b1, {DW{1'b0}}};
                    early   = 1'b1;
                    w_d.st  = CAP_WAIT;
                end else if (pix_valid) begin
                    wr_en   = 1'b1;
                    wr_word = {1'b0, pix_data};
                    w_d.npix = w_q.npix + 1'b1;
                    if (w_q.npix == PCW'(NPIX - 1)) begin
                        wr_word[DW] = 1'b1;
                        w_d.st      = CAP_WAIT;
                    end else if (int'(fifo_count) == DEPTH - 1) begin
                        wr_word[DW] = 1'b1;
                        w_d.ovf     = 1'b1;
                        early       = 1'b1;
                        w_d.st      = CAP_WAIT;
                    end
                end
            end
            default: w_d.st = CAP_WAIT;
        endcase
        if (early && (w_q.trunc != '1)) w_d.trunc = w_q.trunc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q.st    <= CAP_WAIT;
            w_q.npix  <= '0;
            w_q.ovf   <= 1'b0;
            w_q.trunc <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign ovf_flag    = w_q.ovf;
    assign trunc_count = w_q.trunc;

    // R4: while a field is being captured, one slot is always kept free
    p_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == CAP_RUN) |-> (int'(fifo_count) <= DEPTH - 1));
    // R7: the overflow flag never clears
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);
    // R8: the truncation count never decreases
    p_trunc_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (trunc_count >= $past(trunc_count)));
endmodule

// File: rtl/vidcap_framer.sv
module vidcap_framer
    import vidcap_pkg::*;
#(
    parameter int DW       = 24,
    parameter int LINE_PIX = 720,
    parameter int LINES    = 288
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_empty,
    input  logic [DW:0]   head_word,
    input  logic          out_ready,
    output logic          rd_en,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop
);
    typedef struct packed {
        frm_state_e st;
    } fr_t;

    fr_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        rd_en     = 1'b0;
        out_data  = '0;
        out_valid = 1'b0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        case (f_q.st)
            FR_IDLE: begin
                if (!fifo_empty) f_d.st = FR_CTL_KIND;
            end
            FR_CTL_KIND: begin
                out_valid = 1'b1;
                out_sop   = 1'b1;
                out_data  = DW'(KIND_CONTROL);
                if (out_ready) f_d.st = FR_CTL_WIDTH;
            end
            FR_CTL_WIDTH: begin
                out_valid = 1'b1;
                out_data  = DW'(LINE_PIX);
                if (out_ready) f_d.st = FR_CTL_HEIGHT;
            end
            FR_CTL_HEIGHT: begin
                out_valid = 1'b1;
                out_eop   = 1'b1;
                out_data  = DW'(LINES);
                if (out_ready) f_d.st = FR_IMG_KIND;
            end
            FR_IMG_KIND: begin
                out_valid = 1'b1;
                out_sop   = 1'b1;
                out_data  = DW'(KIND_IMAGE);
                if (out_ready) f_d.st = FR_PIXELS;
            end
            FR_PIXELS: begin
                out_valid = !fifo_empty;
                out_data  = head_word[DW-1:0];
                out_eop   = head_word[DW];
                rd_en     = out_valid && out_ready;
                if (rd_en && head_word[DW]) f_d.st = FR_IDLE;
            end
            default: f_d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q.st <= FR_IDLE;
        else        f_q    <= f_d;
    end

    // R10: a stalled beat is held unchanged
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)));
    // R2: every packet opens with a type word
    p_sop_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_data == DW'(KIND_CONTROL) || out_data == DW'(KIND_IMAGE)));
endmodule

// File: rtl/vidcap_packetizer.sv
module vidcap_packetizer #(
    parameter int DW       = 24,
    parameter int LINE_PIX = 720,
    parameter int LINES    = 288,
    parameter int DEPTH    = 64,
    parameter int TW       = 16,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic [DW-1:0] pix_data,
    input  logic          field_start,
    input  logic          locked,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_sop,
    output logic          out_eop,
    output logic          ovf_flag,
    output logic [TW-1:0] trunc_count
);
    logic          wr_en, rd_en, fifo_empty;
    logic [DW:0]   wr_word, head_word;
    logic [CW-1:0] fifo_count;

    vidcap_writer #(
        .DW(DW), .LINE_PIX(LINE_PIX), .LINES(LINES), .DEPTH(DEPTH), .TW(TW)
    ) u_writer (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .field_start(field_start), .locked(locked), .fifo_count(fifo_count),
        .wr_en(wr_en), .wr_word(wr_word), .ovf_flag(ovf_flag),
        .trunc_count(trunc_count)
    );

    vidcap_fifo #(.EW(DW + 1), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .rd_en(rd_en), .head_word(head_word), .count(fifo_count),
        .empty(fifo_empty)
    );

    vidcap_framer #(.DW(DW), .LINE_PIX(LINE_PIX), .LINES(LINES)) u_framer (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .head_word(head_word),
        .out_ready(out_ready), .rd_en(rd_en), .out_data(out_data),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop)
    );
endmodule

// File: tb/sim_vidcap_packetizer.sv
module sim_vidcap_packetizer;
    localparam int DW = 12, LW = 8, LN = 4, DEPTH = 16, TW = 8;
    localparam int NP = LW * LN;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pix_valid = 1'b0, field_start = 1'b0, locked = 1'b1, out_ready = 1'b1;
    logic [DW-1:0] pix_data = '0;
    logic [DW-1:0] out_data;
    logic out_valid, out_sop, out_eop, ovf_flag;
    logic [TW-1:0] trunc_count;

    int checks = 0, errors = 0;
    int rdy_mode = 0;
    int nb = 0;
    logic [DW-1:0] bd [512];
    logic          bs [512];
    logic          be [512];
    bit done = 1'b0;

    always #2 clk = ~clk;

    vidcap_packetizer #(.DW(DW), .LINE_PIX(LW), .LINES(LN), .DEPTH(DEPTH), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .field_start(field_start), .locked(locked), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .ovf_flag(ovf_flag), .trunc_count(trunc_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ready pattern, driven just after each rising edge
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 4 == 0);
                default: out_ready = 1'b0;
            endcase
        end
    end

    // beat recorder and R10 stability check, at the falling edge
    initial begin
        logic pv = 1'b0, pr = 1'b0, pe = 1'b0;
        logic [DW-1:0] pd = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pv && !pr)
                    chk(out_valid && out_data == pd && out_eop == pe,
                        "R10 stalled beat held", int'(out_data), int'(pd));
                if (out_valid && out_ready && nb < 512) begin
                    bd[nb] = out_data; bs[nb] = out_sop; be[nb] = out_eop;
                    nb++;
                end
            end
            pv = out_valid; pr = out_ready; pd = out_data; pe = out_eop;
        end
    end

    task automatic send_field(input int tag, input int npx, input int lock_drop, input bit with_fs);
        for (int i = 0; i < npx; i++) begin
            @(posedge clk); #1;
            if (lock_drop >= 0 && i >= lock_drop) begin
                locked = 1'b0; pix_valid = 1'b0; field_start = 1'b0;
            end else begin
                pix_valid   = 1'b1;
                field_start = with_fs && (i == 0);
                pix_data    = DW'((tag << 8) | i);
            end
        end
        @(posedge clk); #1;
        pix_valid = 1'b0; field_start = 1'b0;
    endtask

    task automatic drain(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // checks the control packet and image type word at base, R2 and R3
    task automatic chk_headers(input int base, input string tst);
        chk(bd[base] == 12'h00F && bs[base] && !be[base], {"R2 control type ", tst}, int'(bd[base]), 15);
        chk(bd[base+1] == DW'(LW), {"R2 width ", tst}, int'(bd[base+1]), LW);
        chk(bd[base+2] == DW'(LN) && be[base+2], {"R2 height+eop ", tst}, int'(bd[base+2]), LN);
        chk(bd[base+3] == 12'h000 && bs[base+3], {"R3 image type ", tst}, int'(bd[base+3]), 0);
    endtask

    // counts pixels matching tag/index in order from base; returns count, last beat eop state
    task automatic payload(input int base, input int tag, output int good, output bit ended);
        good = 0; ended = 1'b0;
        for (int k = base; k < nb; k++) begin
            if (bd[k] != DW'((tag << 8) | good)) break;
            good++;
            if (be[k]) begin ended = 1'b1; break; end
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        chk(!ovf_flag, "R1 ovf_flag after reset", int'(ovf_flag), 0);
        chk(trunc_count == 0, "R1 trunc_count after reset", int'(trunc_count), 0);
    endtask

    task automatic t_full_field(input int tag);
        int base, g; bit e;
        rdy_mode = 0; base = nb;
        send_field(tag, NP, -1, 1'b1);
        drain(100);
        chk(nb - base == NP + 4, "R9 beat count ready high", nb - base, NP + 4);
        chk_headers(base, "full");
        payload(base + 4, tag, g, e);
        chk(g == NP && e, "R3 full payload with eop on last", g, NP);
        chk(trunc_count == 0, "R9 no truncation ready high", int'(trunc_count), 0);
    endtask

    task automatic t_slow_ready;
        int base, g; bit e;
        rdy_mode = 1; base = nb;
        send_field(3, NP, -1, 1'b1);
        drain(300);
        rdy_mode = 0;
        drain(20);
        chk_headers(base, "slow");
        payload(base + 4, 3, g, e);
        chk(e && g < NP && g >= DEPTH - 1, "R4 early eop on unbroken prefix", g, DEPTH);
        chk(nb - base == g + 4, "R6 rest of field dropped", nb - base, g + 4);
        chk(ovf_flag, "R7 flag set on shortfall", int'(ovf_flag), 1);
        chk(trunc_count == 1, "R8 one truncation", int'(trunc_count), 1);
    endtask

    task automatic t_resync;
        int base, g; bit e;
        rdy_mode = 0; base = nb;
        send_field(4, NP, -1, 1'b1);
        drain(100);
        chk_headers(base, "resync");
        payload(base + 4, 4, g, e);
        chk(g == NP && e, "R6 fresh field complete after resync", g, NP);
        chk(ovf_flag, "R7 flag still set", int'(ovf_flag), 1);
        chk(trunc_count == 1, "R8 count unchanged by full field", int'(trunc_count), 1);
    endtask

    task automatic t_lock_loss;
        int base, g, after; bit e;
        rdy_mode = 0; base = nb;
        send_field(7, 14, 10, 1'b1);
        drain(50);
        chk_headers(base, "lock");
        payload(base + 4, 7, g, e);
        chk(g == 10 && !e, "R5 pixels before lock loss", g, 10);
        chk(nb - base == 15 && bd[base+14] == 0 && be[base+14], "R5 terminating beat", nb - base, 15);
        chk(trunc_count == 2, "R8 lock loss counted", int'(trunc_count), 2);
        @(posedge clk); #1; locked = 1'b1;
        after = nb;
        send_field(8, 12, -1, 1'b0);
        drain(50);
        chk(nb == after, "R6 pixels without field start ignored", nb - after, 0);
    endtask

    task automatic t_skip;
        int base, g; bit e;
        rdy_mode = 2; base = nb;
        send_field(5, NP, -1, 1'b1);
        send_field(6, NP, -1, 1'b1);
        drain(10);
        chk(trunc_count == 3, "R11 skipped field not counted", int'(trunc_count), 3);
        rdy_mode = 0;
        drain(100);
        chk_headers(base, "skip");
        payload(base + 4, 5, g, e);
        chk(g == DEPTH && e, "R4 full store delivered, eop on last", g, DEPTH);
        chk(nb - base == DEPTH + 4, "R11 second field produced nothing", nb - base, DEPTH + 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_full_field(1);
        t_full_field(2);
        t_slow_ready();
        t_resync();
        t_lock_loss();
        t_skip();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule